// File: doc/BRIEF.md
# Delayed-Trigger Word Capture Logger

This block sits behind a link deserializer that delivers aligned 32-bit words, and records a chosen stretch of that traffic into an on-chip FIFO. Every stored record carries the word together with a timestamp, so the result is a time-ordered trace. The stretch is chosen by a timer rather than by a pattern match. The timer starts from zero when the observed bus first leaves reset, and capture opens once the timer equals a programmable delay. A long trace is built from several runs, each with a later delay.

The observed bus may pass through reset several times while it boots. The logger arms on the first reset pulse it sees after power-up or after a re-arm, and it ignores all later pulses. With the zero filter on, words that are entirely zero are dropped before they reach the FIFO, so idle traffic does not use storage. Once capture is open it runs until the FIFO fills. After that, further words are discarded and a sticky overflow flag is raised. A re-arm pulse empties the FIFO, clears the flags and forgets the first reset, so a new run can begin.

Top module: `trig_capture_logger`

## Requirements
- R1: While `rst_n` is low, and after it rises, `armed_o`, `triggered_o`, `overflow_o` and `full_o` are 0 and `empty_o` is 1.
- R2: `bus_rst_i` is active high. After reset or re-arm, the first high `bus_rst_i` is noted. At the first clock edge after that where `bus_rst_i` is sampled low, the timer restarts at 0 and `armed_o` goes to 1. `armed_o` stays at 1 until the trigger fires.
- R3: Once the timer has been started, later pulses on `bus_rst_i` neither restart the timer nor change `armed_o` or `triggered_o`.
- R4: The capture window opens in the cycle where the timer equals `delay_i`. That cycle and every later one are inside the window, and valid words before it are discarded. From the edge that ends that cycle, `triggered_o` is 1 and `armed_o` is 0. A delay of 0 opens the window in the first cycle after the release.
- R5: A record holds `rec_ts_o` and `rec_data_o`. `rec_ts_o` is the timer value in the cycle the word was accepted, where 0 is the first cycle after the release. `rec_data_o` is the word. The timer advances by one every cycle, whether or not a word is stored.
- R6: When `zero_skip_i` is 1, a valid word equal to 0 inside the window is not stored. When `zero_skip_i` is 0, every valid word inside the window is stored.
- R7: The FIFO is first-in first-out and show-ahead. The oldest record is on `rec_ts_o`/`rec_data_o` whenever `empty_o` is 0. `rd_en_i` removes it at the clock edge. `rd_en_i` while `empty_o` is 1 has no effect.
- R8: `full_o` is 1 when DEPTH records are held. A word that would be stored while `full_o` is 1 is discarded, even if a read happens in the same cycle, and it sets `overflow_o`. `overflow_o` stays at 1 until re-arm. A word removed by the zero filter never sets `overflow_o`.
- R9: `rearm_i` high at a clock edge empties the FIFO and clears `overflow_o`, `triggered_o`, `armed_o` and the first-reset memory. It takes priority over every other input in that cycle. The next `bus_rst_i` pulse then arms a new run.
- R10: A word accepted at a clock edge is visible at the read port right after that same edge, with `empty_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rearm_i | input | 1 | Single-cycle pulse that starts a new run |
| delay_i | input | TS_W (32) | Trigger delay in cycles after the bus reset release |
| zero_skip_i | input | 1 | 1 = drop all-zero words |
| bus_rst_i | input | 1 | Observed bus reset, active high |
| word_vld_i | input | 1 | `word_i` carries a word this cycle |
| word_i | input | DATA_W (32) | Aligned word from the deserializer |
| rd_en_i | input | 1 | Remove the oldest record |
| rec_ts_o | output | TS_W (32) | Timestamp of the oldest record |
| rec_data_o | output | DATA_W (32) | Data word of the oldest record |
| empty_o | output | 1 | FIFO holds no record |
| full_o | output | 1 | FIFO holds DEPTH records |
| armed_o | output | 1 | Timer running, window not yet open |
| triggered_o | output | 1 | Capture window open |
| overflow_o | output | 1 | Sticky: a word was lost to a full FIFO |

## Verification
Every result of this block is due exactly one clock edge after the stimulus. The timer restart, the arm and trigger flags, the stored record and the FIFO flags all show the effect of inputs sampled at an edge just after that same edge, and the timestamp of a record is the timer value in the cycle before that edge. The bench drives inputs at the falling edge. It advances its own model of the run state, timer and FIFO at the rising edge, and compares every output 1 ns later, so each check lands in the cycle where the result first becomes due. Directed checks then confirm hand-computed values: the first timestamp equal to the delay, a delay of zero, suppression, overflow and re-arm.

// File: rtl/cap_pkg.sv
package cap_pkg;

  // Run state of the delayed trigger
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // waiting for the first bus reset
    ST_INRST = 2'd1,  // bus held in its first reset
    ST_ARMED = 2'd2,  // timer running toward the delay
    ST_TRIG  = 2'd3   // window open
  } run_state_e;

endpackage

// File: rtl/cap_trigger.sv
module cap_trigger
  import cap_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rearm_i,
  input  logic            bus_rst_i,
  input  logic [TS_W-1:0] delay_i,
  output logic [TS_W-1:0] ts_o,
  output logic            win_o,
  output logic            armed_o,
  output logic            trig_o
);

  run_state_e      st_q, st_d;
  logic [TS_W-1:0] ts_q, ts_d;
  logic            hit;
  logic            st_en;

  // Comparator: fires in the cycle the timer reaches the delay
  assign hit = (st_q == ST_ARMED) && (ts_q == delay_i);

  always_comb begin
    ts_d = ts_q + TS_W'(1);
    if ((st_q == ST_INRST) && !bus_rst_i) begin
      ts_d = '0;
    end
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (bus_rst_i)  st_d = ST_INRST;
      ST_INRST: if (!bus_rst_i) st_d = ST_ARMED;
      ST_ARMED: if (hit)        st_d = ST_TRIG;
      default:                  st_d = ST_TRIG;
    endcase
    if (rearm_i) begin
      st_d = ST_IDLE;
    end
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q <= '0;
    end else begin
      ts_q <= ts_d;
    end
  end

  assign ts_o    = ts_q;
  assign win_o   = hit || (st_q == ST_TRIG);
  assign armed_o = (st_q == ST_ARMED);
  assign trig_o  = (st_q == ST_TRIG);

endmodule

// File: rtl/cap_filter.sv
module cap_filter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rearm_i,
  input  logic              win_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              zero_skip_i,
  input  logic              full_i,
  output logic              push_o,
  output logic              ovf_o
);

  logic is_zero;
  logic accept;
  logic ovf_q, ovf_d, ovf_en;

  assign is_zero = (word_i == '0);
  assign accept  = win_i && vld_i && !(zero_skip_i && is_zero);
  assign push_o  = accept && !full_i && !rearm_i;

  always_comb begin
    ovf_d = ovf_q;
    if (rearm_i) begin
      ovf_d = 1'b0;
    end else if (accept && full_i) begin
      ovf_d = 1'b1;
    end
  end

  assign ovf_en = (ovf_d != ovf_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else if (ovf_en) begin
      ovf_q <= ovf_d;
    end
  end

  assign ovf_o = ovf_q;

endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_req_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);

  localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int  CW   = $clog2(DEPTH + 1);
  localparam bit  POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, wp_inc;
  logic [AW-1:0] rp_q, rp_d, rp_inc;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop;
  logic          ptr_en;

  generate
    if (POW2) begin : g_pow2
      assign wp_inc = wp_q + AW'(1);
      assign rp_inc = rp_q + AW'(1);
    end else begin : g_wrap
      assign wp_inc = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      assign rp_inc = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    end
  endgenerate

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign pop     = pop_req_i && !empty_o;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_i) wp_d = wp_inc;
      if (pop)    rp_d = rp_inc;
      cnt_d = cnt_q + CW'(push_i) - CW'(pop);
    end
  end

  assign ptr_en = flush_i || push_i || pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      mem[wp_q] <= wdata_i;
    end
  end

  assign rdata_o = mem[rp_q];

endmodule

// File: rtl/trig_capture_logger.sv
module trig_capture_logger #(
  parameter int DATA_W = 32,
  parameter int TS_W   = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rearm_i,
  input  logic [TS_W-1:0]   delay_i,
  input  logic              zero_skip_i,
  input  logic              bus_rst_i,
  input  logic              word_vld_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              rd_en_i,
  output logic [TS_W-1:0]   rec_ts_o,
  output logic [DATA_W-1:0] rec_data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              armed_o,
  output logic              triggered_o,
  output logic              overflow_o
);

  localparam int REC_W = TS_W + DATA_W;

  logic [TS_W-1:0]  ts;
  logic             win;
  logic             push;
  logic [REC_W-1:0] rec_in;
  logic [REC_W-1:0] rec_out;

  cap_trigger #(.TS_W(TS_W)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .rearm_i   (rearm_i),
    .bus_rst_i (bus_rst_i),
    .delay_i   (delay_i),
    .ts_o      (ts),
    .win_o     (win),
    .armed_o   (armed_o),
    .trig_o    (triggered_o)
  );

  cap_filter #(.DATA_W(DATA_W)) u_filt (
    .clk         (clk),
    .rst_n       (rst_n),
    .rearm_i     (rearm_i),
    .win_i       (win),
    .vld_i       (word_vld_i),
    .word_i      (word_i),
    .zero_skip_i (zero_skip_i),
    .full_i      (full_o),
    .push_o      (push),
    .ovf_o       (overflow_o)
  );

  assign rec_in = {ts, word_i};

  cap_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_i   (rearm_i),
    .push_i    (push),
    .wdata_i   (rec_in),
    .pop_req_i (rd_en_i),
    .rdata_o   (rec_out),
    .empty_o   (empty_o),
    .full_o    (full_o)
  );

  assign rec_ts_o   = rec_out[REC_W-1:DATA_W];
  assign rec_data_o = rec_out[DATA_W-1:0];

endmodule

// File: rtl/cap_logger_chk.sv
module cap_logger_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rearm_i,
  input logic              bus_rst_i,
  input logic              word_vld_i,
  input logic [DATA_W-1:0] word_i,
  input logic              zero_skip_i,
  input logic              empty_o,
  input logic              full_o,
  input logic              armed_o,
  input logic              triggered_o,
  input logic              overflow_o
);

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o && !rearm_i |=> overflow_o);

  // R4
  trig_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    triggered_o && !rearm_i |=> triggered_o);

  // R9
  rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i |=> empty_o && !overflow_o && !triggered_o && !armed_o);

  // R2
  armed_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed_o && triggered_o));

  // R3
  late_reset_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o && bus_rst_i && !rearm_i |=> armed_o || triggered_o);

  // R8
  full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !empty_o);

  // R7
  idle_stays_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o && !word_vld_i && !rearm_i |=> empty_o);

  // R6
  zero_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o && zero_skip_i && word_vld_i && (word_i == '0) && !rearm_i |=> empty_o);

endmodule

bind trig_capture_logger cap_logger_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rearm_i     (rearm_i),
  .bus_rst_i   (bus_rst_i),
  .word_vld_i  (word_vld_i),
  .word_i      (word_i),
  .zero_skip_i (zero_skip_i),
  .empty_o     (empty_o),
  .full_o      (full_o),
  .armed_o     (armed_o),
  .triggered_o (triggered_o),
  .overflow_o  (overflow_o)
);

// File: tb/trig_capture_logger_test.sv
`timescale 1ns/1ps
module trig_capture_logger_test;

  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rearm, zs, bus_rst, vld, rd_en;
  logic [31:0] delay, word;
  logic [31:0] rec_ts_o, rec_data_o;
  logic        empty_o, full_o, armed_o, triggered_o, overflow_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model
  int          m_st;
  logic [31:0] m_ts;
  int          m_head, m_cnt;
  logic        m_ovf;
  logic [31:0] m_qts [D];
  logic [31:0] m_qd  [D];

  always #2.5 clk = ~clk;

  trig_capture_logger #(.DATA_W(32), .TS_W(32), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .rearm_i(rearm), .delay_i(delay),
    .zero_skip_i(zs), .bus_rst_i(bus_rst), .word_vld_i(vld), .word_i(word),
    .rd_en_i(rd_en), .rec_ts_o(rec_ts_o), .rec_data_o(rec_data_o),
    .empty_o(empty_o), .full_o(full_o), .armed_o(armed_o),
    .triggered_o(triggered_o), .overflow_o(overflow_o)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_step();
    int          st_n;
    logic [31:0] ts_n;
    bit          hit, win, acc, mfull, pop;
    int          tail;
    st_n = m_st;
    hit  = (m_st == 2) && (m_ts == delay);
    win  = hit || (m_st == 3);
    acc  = vld && win && !(zs && (word == 32'd0));
    ts_n = ((m_st == 1) && !bus_rst) ? 32'd0 : m_ts + 32'd1;
    case (m_st)
      0: if (bus_rst)  st_n = 1;
      1: if (!bus_rst) st_n = 2;
      2: if (hit)      st_n = 3;
      default: ;
    endcase
    if (rearm) begin
      st_n = 0; m_cnt = 0; m_head = 0; m_ovf = 1'b0;
    end else begin
      tail  = (m_head + m_cnt) % D;
      mfull = (m_cnt == D);
      pop   = rd_en && (m_cnt > 0);
      if (acc && mfull) m_ovf = 1'b1;
      if (pop) begin m_head = (m_head + 1) % D; m_cnt--; end
      if (acc && !mfull) begin
        m_qts[tail] = m_ts; m_qd[tail] = word; m_cnt++;
      end
    end
    m_st = st_n;
    m_ts = ts_n;
  endtask

  task automatic compare();
    chk("R2 armed_o",     64'(armed_o),     64'(m_st == 2));
    chk("R4 triggered_o", 64'(triggered_o), 64'(m_st == 3));
    chk("R7 empty_o",     64'(empty_o),     64'(m_cnt == 0));
    chk("R8 full_o",      64'(full_o),      64'(m_cnt == D));
    chk("R8 overflow_o",  64'(overflow_o),  64'(m_ovf));
    if (m_cnt > 0) begin
      chk("R5 rec_ts_o",   64'(rec_ts_o),   64'(m_qts[m_head]));
      chk("R5 rec_data_o", 64'(rec_data_o), 64'(m_qd[m_head]));
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #1;
    compare();
    @(negedge clk);
  endtask

  task automatic idle_in();
    rearm = 1'b0; bus_rst = 1'b0; vld = 1'b0; word = 32'd0; rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int r;
    r = $urandom(32'd20240611);
    rst_n = 1'b0; zs = 1'b0; delay = 32'd5;
    idle_in();
    m_st = 0; m_ts = 32'd0; m_head = 0; m_cnt = 0; m_ovf = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 armed_o at reset",     64'(armed_o),     64'd0);
    chk("R1 triggered_o at reset", 64'(triggered_o), 64'd0);
    chk("R1 overflow_o at reset",  64'(overflow_o),  64'd0);
    chk("R1 full_o at reset",      64'(full_o),      64'd0);
    chk("R1 empty_o at reset",     64'(empty_o),     64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: words before any bus reset are discarded
    for (int i = 0; i < 3; i++) begin vld = 1'b1; word = 32'hDEAD_0000 + 32'(i); cyc(); end
    chk("R4 no capture before bus reset", 64'(empty_o), 64'd1);

    // R2: first bus reset, words during reset discarded
    bus_rst = 1'b1;
    for (int i = 0; i < 3; i++) cyc();
    bus_rst = 1'b0; vld = 1'b0;
    cyc();
    chk("R2 armed after release", 64'(armed_o), 64'd1);
    // words with timer 0..7, delay 5
    for (int i = 0; i < 8; i++) begin vld = 1'b1; word = 32'hA000_0000 + 32'(i); cyc(); end
    chk("R5 first record timestamp equals delay", 64'(rec_ts_o), 64'd5);
    chk("R4 first record is word at delay", 64'(rec_data_o), 64'hA000_0005);

    // R3: second bus reset pulse is ignored
    vld = 1'b0; bus_rst = 1'b1;
    for (int i = 0; i < 2; i++) cyc();
    bus_rst = 1'b0;
    cyc();
    chk("R3 triggered held over later bus reset", 64'(triggered_o), 64'd1);

    // R7: drain, including reads while empty
    rd_en = 1'b1;
    for (int i = 0; i < 6; i++) cyc();
    rd_en = 1'b0;
    chk("R7 drained FIFO empty", 64'(empty_o), 64'd1);

    // R6: zero filter on, then off
    zs = 1'b1; vld = 1'b1; word = 32'd0;
    cyc();
    chk("R6 zero word dropped with filter on", 64'(empty_o), 64'd1);
    zs = 1'b0;
    cyc();
    chk("R10 zero word visible one edge later", 64'(empty_o), 64'd0);
    chk("R6 zero word stored with filter off", 64'(rec_data_o), 64'd0);
    vld = 1'b0; rd_en = 1'b1; cyc(); rd_en = 1'b0;

    // R8: fill and overflow
    for (int i = 0; i < D + 4; i++) begin vld = 1'b1; word = 32'hB000_0000 + 32'(i); cyc(); end
    chk("R8 full after DEPTH words", 64'(full_o), 64'd1);
    chk("R8 overflow set", 64'(overflow_o), 64'd1);
    chk("R8 oldest record kept", 64'(rec_data_o), 64'hB000_0000);
    vld = 1'b1; rd_en = 1'b1; word = 32'hC000_0001; cyc();
    chk("R8 write blocked while full even with read", 64'(full_o), 64'd0);
    idle_in();

    // R9: re-arm clears everything
    rearm = 1'b1; cyc(); rearm = 1'b0;
    chk("R9 empty after rearm",     64'(empty_o),     64'd1);
    chk("R9 overflow cleared",      64'(overflow_o),  64'd0);
    chk("R9 triggered cleared",     64'(triggered_o), 64'd0);
    chk("R9 armed cleared",         64'(armed_o),     64'd0);
    // new run, delay 0
    delay = 32'd0;
    bus_rst = 1'b1; cyc();
    bus_rst = 1'b0; cyc();
    vld = 1'b1; word = 32'h0000_1234; cyc();
    chk("R10 record visible after accepting edge", 64'(empty_o), 64'd0);
    chk("R4 delay zero stamps first cycle", 64'(rec_ts_o), 64'd0);
    chk("R4 delay zero data", 64'(rec_data_o), 64'h0000_1234);
    idle_in();

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      rearm   = ($urandom_range(999) < 3);
      bus_rst = ($urandom_range(99) < 4);
      vld     = ($urandom_range(99) < 70);
      word    = ($urandom_range(9) < 3) ? 32'd0 : $urandom();
      rd_en   = ($urandom_range(99) < 40);
      if ($urandom_range(99) < 2) zs = ~zs;
      if (rearm) delay = $urandom_range(40);
      cyc();
    end
    finish_run();
  end

endmodule